// File: doc/BRIEF.md
# Sampling Trace Event Counter

This block is a per-thread performance sampler. A 64-bit control word enables it, picks between trace and accumulation behaviour and supplies a base address. A second 64-bit word supplies a sampling interval, two event selectors and a ring size. While it is enabled, a down-counter runs through the interval. Each time the interval runs out, the counter reloads and the block builds a memory record.

In trace mode the record holds four words: the current program counter, both event counts and a free-running cycle stamp. The record goes to the next 32-byte slot of a circular buffer, and the buffer wraps back to its base without any signal. In accumulation mode the record holds only the two event counts, and each one is always written over the same two words at the base address. The records leave through a plain request/ready write port, one 64-bit word per accepted cycle. If an interval runs out while the previous record still has words outstanding, the new sample is discarded and counted internally.

Top module: `sample_trace_unit`

## Requirements
- R1: In the control word, value bit 63 enables the unit and value bit 62 selects trace mode (1) or accumulation mode (0). The base address is the control word with every bit cleared except bits 55:13. All other control bits have no effect.
- R2: In the configuration word, bits 61:30 are the 32-bit interval load, bits 29:23 are selector 1, bits 22:16 are selector 2, and bits 15:13 are the ring size code. All other bits have no effect.
- R3: The first clock edge that sees the enable bit set arms the counter with the load value L. An interval then expires every L+1 active edges. A request becomes visible L+2 cycles after enable is driven, and the counter reloads at every expiry.
- R4: A trace record is four words written to base+offset+0, +8, +16 and +24. They are, in order, the program counter, event count 1 and event count 2 as they stood before the expiry edge, and the cycle stamp (edges since reset). The offset then grows by 32.
- R5: The ring holds 4096 << size-code bytes. The offset wraps to 0 at that size, so writes return to the base address silently.
- R6: In accumulation mode each expiry writes count 1 to the base address and count 2 to base+8. No program counter is written and the offset does not move.
- R7: Selector 0 counts every active cycle. Selector k in the range 1 to NUM_EV counts cycles with event_strobe_i[k-1] high. Larger selectors count nothing. Both counts start at 0 on enable.
- R8: An expiry that comes while an earlier record still has words outstanding (including a word being accepted on that same edge) is dropped, and the internal lost counter increments. The earlier record completes unchanged.
- R9: While mem_req_o is high and mem_ready_i is low, the address and data are held. Each accepted word advances to the next word of the record.
- R10: Clearing the enable bit stops counting at once, and a record already started still finishes. Setting enable again restarts at offset 0 with zeroed counts.
- R11: After reset no write is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg_i | input | 64 | Enable, mode and base address word |
| trace_cfg_i | input | 64 | Interval, selectors and ring size word |
| event_strobe_i | input | NUM_EV | Per-cycle event pulses |
| pc_i | input | 64 | Current program counter |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 64 | Byte address of the word |
| mem_wdata_o | output | 64 | Word to write |
| mem_ready_i | input | 1 | Memory accepts the word this cycle |

## Verification
A miscounting interval counter moves the first request and every later request by whole cycles, so the per-cycle comparison reports it on the first record. A corrupt offset or a wrong wrap boundary puts a wrong address on the port no later than the next record, or at the latest the record after the ring fills. A wrong event count or a misfiring busy flag (a dropped sample that should have been kept, or the reverse) shows up as a mismatched data word or as a request arriving in the wrong cycle, within one sampling period.

// File: rtl/sample_trace_pkg.sv
package sample_trace_pkg;
  localparam int WORD_W    = 64;
  localparam int REC_WORDS = 4;
  localparam int REC_BYTES = REC_WORDS * 8;
  localparam int SIZE_W    = 3;
  localparam int MIN_LOG2  = 12;
  localparam int OFF_W     = MIN_LOG2 + (1 << SIZE_W) - 1;
  localparam int LOAD_W    = 32;
  localparam int SEL_W     = 7;

  typedef struct packed {
    logic              enable;
    logic              trace;
    logic [WORD_W-1:0] base;
  } mode_t;

  typedef struct packed {
    logic [LOAD_W-1:0] load;
    logic [SEL_W-1:0]  sel1;
    logic [SEL_W-1:0]  sel2;
    logic [SIZE_W-1:0] size;
  } cfg_t;

  function automatic mode_t decode_mode(input logic [WORD_W-1:0] r);
    mode_t m;
    m.enable = r[63];
    m.trace  = r[62];
    m.base   = {8'h00, r[55:13], 13'h0000};
    return m;
  endfunction

  function automatic cfg_t decode_cfg(input logic [WORD_W-1:0] r);
    cfg_t c;
    c.load = r[61:30];
    c.sel1 = r[29:23];
    c.sel2 = r[22:16];
    c.size = r[15:13];
    return c;
  endfunction

  function automatic logic [OFF_W-1:0] buf_mask(input logic [SIZE_W-1:0] code);
    logic [OFF_W:0] full;
    full = (OFF_W+1)'(1) << (MIN_LOG2 + int'(code));
    return OFF_W'(full - 1'b1);
  endfunction

  function automatic logic [OFF_W-1:0] next_offset(input logic [OFF_W-1:0] off,
                                                   input logic [SIZE_W-1:0] code);
    return (off + OFF_W'(REC_BYTES)) & buf_mask(code);
  endfunction
endpackage

// File: rtl/sample_interval.sv
module sample_interval #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (start_i)  cnt_q <= load_i;
    else if (run_i) begin
      if (expire_o)    cnt_q <= load_i;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !expire_o |=> cnt_q == $past(cnt_q) - 1'b1);
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> cnt_q == $past(load_i));
endmodule

// File: rtl/sample_event_count.sv
module sample_event_count #(
  parameter int NUM_EV = 8,
  parameter int SEL_W  = 7,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [NUM_EV-1:0] strobe_i,
  output logic [CNT_W-1:0]  count_o
);
  logic hit;

  always_comb begin
    hit = (sel_i == '0);
    for (int k = 1; k <= NUM_EV; k++)
      if (int'(sel_i) == k) hit = strobe_i[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_o <= '0;
    else if (clear_i)        count_o <= '0;
    else if (run_i && hit)   count_o <= count_o + 1'b1;
  end

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !clear_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/sample_record_writer.sv
module sample_record_writer
  import sample_trace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              expire_i,
  input  logic              trace_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] cnt1_i,
  input  logic [WORD_W-1:0] cnt2_i,
  input  logic [WORD_W-1:0] stamp_i,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i
);
  localparam int IDX_W = $clog2(REC_WORDS);

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] rec_q [REC_WORDS];
  logic [OFF_W-1:0]  off_q;
  logic [31:0]       lost_q;
  logic              lost_unused;

  // named internal events
  logic accept_ev, drop_ev, word_done_ev;
  assign accept_ev    = expire_i && !busy_q;
  assign drop_ev      = expire_i && busy_q;
  assign word_done_ev = busy_q && mem_ready_i;
  assign lost_unused  = ^lost_q;

  assign mem_req_o   = busy_q;
  assign mem_addr_o  = addr_q + (WORD_W'(idx_q) << 3);
  assign mem_wdata_o = rec_q[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      addr_q <= '0;
      off_q  <= '0;
      lost_q <= '0;
      for (int i = 0; i < REC_WORDS; i++) rec_q[i] <= '0;
    end else begin
      if (restart_i) off_q <= '0;
      if (drop_ev)   lost_q <= lost_q + 1'b1;
      if (word_done_ev) begin
        if (idx_q == last_q) busy_q <= 1'b0;
        else                 idx_q  <= idx_q + 1'b1;
      end
      if (accept_ev) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        if (trace_i) begin
          last_q   <= IDX_W'(REC_WORDS - 1);
          addr_q   <= base_i + WORD_W'(off_q);
          rec_q[0] <= pc_i;
          rec_q[1] <= cnt1_i;
          rec_q[2] <= cnt2_i;
          rec_q[3] <= stamp_i;
          off_q    <= next_offset(off_q, size_i);
        end else begin
          last_q   <= IDX_W'(1);
          addr_q   <= base_i;
          rec_q[0] <= cnt1_i;
          rec_q[1] <= cnt2_i;
        end
      end
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));
  // R8
  lost_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> lost_q == $past(lost_q) + 1'b1);
  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !expire_i && !busy_q |=> !mem_req_o);
  // R5
  offset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && trace_i && !restart_i |=> off_q <= $past(buf_mask(size_i)));
endmodule

// File: rtl/sample_trace_unit.sv
module sample_trace_unit
  import sample_trace_pkg::*;
#(
  parameter int NUM_EV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       mode_reg_i,
  input  logic [63:0]       trace_cfg_i,
  input  logic [NUM_EV-1:0] event_strobe_i,
  input  logic [63:0]       pc_i,
  output logic              mem_req_o,
  output logic [63:0]       mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_ready_i
);
  mode_t md;
  cfg_t  cf;
  logic  active_q, start_ev, run_ev, expire_ev;
  logic [WORD_W-1:0] stamp_q;
  logic [WORD_W-1:0] counts [2];
  logic [SEL_W-1:0]  sels   [2];
  logic  cfg_unused;

  assign md = decode_mode(mode_reg_i);
  assign cf = decode_cfg(trace_cfg_i);
  assign cfg_unused = ^{mode_reg_i[61:56], mode_reg_i[12:0],
                        trace_cfg_i[63:62], trace_cfg_i[12:0]};

  assign start_ev = md.enable && !active_q;
  assign run_ev   = md.enable && active_q;
  assign sels[0]  = cf.sel1;
  assign sels[1]  = cf.sel2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      stamp_q  <= '0;
    end else begin
      active_q <= md.enable;
      stamp_q  <= stamp_q + 1'b1;
    end
  end

  sample_interval #(.CNT_W(LOAD_W)) u_interval (
    .clk(clk), .rst_n(rst_n), .start_i(start_ev), .run_i(run_ev),
    .load_i(cf.load), .expire_o(expire_ev)
  );

  for (genvar g = 0; g < 2; g++) begin : g_evcnt
    sample_event_count #(.NUM_EV(NUM_EV), .SEL_W(SEL_W), .CNT_W(WORD_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear_i(start_ev), .run_i(run_ev),
      .sel_i(sels[g]), .strobe_i(event_strobe_i), .count_o(counts[g])
    );
  end

  sample_record_writer u_writer (
    .clk(clk), .rst_n(rst_n), .restart_i(start_ev), .expire_i(expire_ev),
    .trace_i(md.trace), .size_i(cf.size), .base_i(md.base), .pc_i(pc_i),
    .cnt1_i(counts[0]), .cnt2_i(counts[1]), .stamp_i(stamp_q),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i)
  );
endmodule

// File: tb/sample_trace_unit_bench.sv
module sample_trace_unit_bench;
  localparam int NEV = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] mode_reg = '0, cfg = '0, pc = '0;
  logic [NEV-1:0] strobe = '0;
  logic ready = 1'b1;
  logic req;
  logic [63:0] addr, wdata;

  always #2 clk = ~clk;

  sample_trace_unit #(.NUM_EV(NEV)) u_sample_trace_unit (
    .clk(clk), .rst_n(rst_n), .mode_reg_i(mode_reg), .trace_cfg_i(cfg),
    .event_strobe_i(strobe), .pc_i(pc), .mem_req_o(req), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_ready_i(ready)
  );

  int errors = 0, checks = 0, cycles = 0, wrap_hits = 0;
  string tag = "R11";
  bit compare_on = 1'b0;
  logic [63:0] wrap_base = '0;

  // behavioural reference
  bit          m_active = 0;
  longint unsigned m_cnt = 0;
  logic [63:0] m_c1 = 0, m_c2 = 0, m_ts = 0;
  int          m_off = 0, m_lost = 0;
  logic [63:0] qa[$], qd[$];

  function automatic logic [63:0] mk_mode(bit en, bit tr, logic [63:0] base, logic [63:0] junk);
    logic [63:0] v;
    v = (base & 64'h00FF_FFFF_FFFF_E000) | (junk & 64'h3F00_0000_0000_1FFF);
    v[63] = en; v[62] = tr;
    return v;
  endfunction

  function automatic logic [63:0] mk_cfg(int unsigned load, int s1, int s2, int sz);
    logic [63:0] v;
    v = 64'hC000_0000_0000_1ABC;
    v[61:30] = load; v[29:23] = 7'(s1); v[22:16] = 7'(s2); v[15:13] = 3'(sz);
    return v;
  endfunction

  function automatic bit ev_hit(int s);
    if (s == 0) return 1'b1;
    if (s <= NEV) return strobe[s-1];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_cnt = 0; m_c1 = 0; m_c2 = 0; m_ts = 0; m_off = 0;
      qa.delete(); qd.delete();
    end else begin
      bit pend, en, tr, exp_ev;
      logic [63:0] base, s1v, s2v;
      int unsigned load; int s1, s2, sz;
      pend = qa.size() > 0;
      if (compare_on && req && ready && addr == wrap_base) wrap_hits++;
      if (pend && ready) begin void'(qa.pop_front()); void'(qd.pop_front()); end
      en = mode_reg[63]; tr = mode_reg[62];
      base = mode_reg & 64'h00FF_FFFF_FFFF_E000;
      load = int'((cfg >> 30) & 64'hFFFF_FFFF);
      s1 = int'((cfg >> 23) & 64'h7F); s2 = int'((cfg >> 16) & 64'h7F);
      sz = int'((cfg >> 13) & 64'h7);
      if (!en) m_active = 0;
      else if (!m_active) begin
        m_active = 1; m_cnt = load; m_c1 = 0; m_c2 = 0; m_off = 0;
      end else begin
        exp_ev = (m_cnt == 0);
        if (exp_ev) m_cnt = load; else m_cnt--;
        s1v = m_c1; s2v = m_c2;
        if (ev_hit(s1)) m_c1++;
        if (ev_hit(s2)) m_c2++;
        if (exp_ev) begin
          if (pend) m_lost++;
          else if (tr) begin
            qa.push_back(base + m_off);      qd.push_back(pc);
            qa.push_back(base + m_off + 8);  qd.push_back(s1v);
            qa.push_back(base + m_off + 16); qd.push_back(s2v);
            qa.push_back(base + m_off + 24); qd.push_back(m_ts);
            m_off = (m_off + 32) & ((4096 << sz) - 1);
          end else begin
            qa.push_back(base);     qd.push_back(s1v);
            qa.push_back(base + 8); qd.push_back(s2v);
          end
        end
      end
      m_ts++;
    end
  end

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      bit ereq;
      ereq = qa.size() > 0;
      check(req == ereq, "mem_req", 64'(req), 64'(ereq));
      if (ereq && req) begin
        check(addr == qa[0], "mem_addr", addr, qa[0]);
        check(wdata == qd[0], "mem_wdata", wdata, qd[0]);
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  // stimulus on pc and strobes every cycle
  always @(negedge clk) begin
    pc <= {$urandom, $urandom};
    strobe <= NEV'($urandom);
  end

  task automatic run(int n, bit rand_ready);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ready = rand_ready ? 1'($urandom) : 1'b1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mode_reg = '0; ready = 1'b1;
    while (qa.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(req == 1'b0, "request during reset", 64'(req), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req == 1'b0, "request after reset", 64'(req), 64'h0);
    compare_on = 1'b1;

    // R3: first request timing, then periodic reload (R4 records)
    tag = "R3";
    cfg = mk_cfg(3, 0, 2, 0);
    mode_reg = mk_mode(1, 1, 64'h0000_0000_1234_0000, '0);
    begin
      int n = 0;
      while (!req && n < 20) begin @(negedge clk); n++; end
      check(n == 5, "first request delay", 64'(n), 64'd5);
    end
    tag = "R4";
    run(60, 0);
    idle();

    // R5: ring wrap at 4 KiB with reserved bits set (R1, R2)
    tag = "R5";
    wrap_base = 64'h0000_0000_0040_0000;
    wrap_hits = 0;
    cfg = mk_cfg(7, 3, 0, 0);
    mode_reg = mk_mode(1, 1, wrap_base, 64'hFFFF_FFFF_FFFF_FFFF);
    run(135 * 8, 0);
    idle();
    check(wrap_hits == 2, "wrap returns to base", 64'(wrap_hits), 64'd2);

    // R1/R2: larger ring code and another base
    tag = "R2";
    cfg = mk_cfg(9, 5, 1, 3);
    mode_reg = mk_mode(1, 1, 64'h0012_3456_0000_0000, 64'h2A00_0000_0000_0555);
    run(200, 0);
    idle();

    // R8/R9: back-pressure with drops
    tag = "R8";
    cfg = mk_cfg(2, 0, 4, 1);
    mode_reg = mk_mode(1, 1, 64'h0000_0000_0080_0000, '0);
    run(400, 1);
    idle();
    check(m_lost > 0, "samples were dropped under back-pressure", 64'(m_lost), 64'd1);

    // R6: accumulation mode
    tag = "R6";
    cfg = mk_cfg(4, 1, 3, 2);
    mode_reg = mk_mode(1, 0, 64'h0000_0000_0000_6000, '0);
    run(150, 1);
    idle();

    // R7: out-of-range selector counts nothing, top selector index
    tag = "R7";
    cfg = mk_cfg(5, 100, NEV, 0);
    mode_reg = mk_mode(1, 1, 64'h0000_0000_0001_0000, '0);
    run(120, 0);
    idle();

    // R10: disable while a record is held, then re-enable at a new base
    tag = "R10";
    cfg = mk_cfg(3, 0, 0, 0);
    mode_reg = mk_mode(1, 1, 64'h0000_0000_0002_0000, '0);
    ready = 1'b0;
    while (!req) @(negedge clk);
    repeat (2) @(negedge clk);
    mode_reg = '0;
    repeat (6) @(negedge clk);
    ready = 1'b1;
    repeat (10) @(negedge clk);
    check(req == 1'b0, "idle after disable drains", 64'(req), 64'h0);
    mode_reg = mk_mode(1, 1, 64'h0000_0000_0003_0000, '0);
    run(40, 0);
    idle();

    finish_run();
  end
endmodule